// File: doc/BRIEF.md
# Clause 22 MDIO Management Frame Engine

This block is a management-bus master for PHY devices using Clause 22 framing. Software programs a clock divider and a preamble switch, then writes one 32-bit word into the command/data register. That word already is the whole frame: start bits, opcode, PHY address, register address, turnaround and data. Writing it starts the transfer. The engine sends it on the MDIO line, most significant bit first, on a management clock divided down from the system clock. When the preamble is enabled, 32 ones go out first.

For a read (opcode bits 29:28 equal to binary 10), the engine releases the line from the second turnaround bit onward. It then shifts in the 16 bits the PHY returns and places them in bits 15:0 of the same data register. The upper half is left as software wrote it. At the end of every frame a sticky completion flag is set, and software clears it by writing a one. An interrupt output reports that flag unless the mask bit blocks it. Writes to the data register while a frame is in flight are dropped.

Register map on the 2-bit address port:
- Address 0 is configuration. Bits 6:0 hold the divider and bit 7 enables the preamble.
- Address 1 is the command/data word.
- Address 2 is status. Bit 0 is the completion flag (write one to clear) and bit 1 is busy (read only).
- Address 3 is the mask. Bit 0 set lets the completion flag reach the interrupt.

Top module: `mdio_frame_engine`

## Requirements
- R1: After reset, all four registers read as zero, and MDC, the MDIO output enable and the interrupt output are low.
- R2: With configuration bit 7 set, the frame is 32 ones followed by the 32-bit command word, MSB first, for 64 MDC cycles in total. With bit 7 clear, only the 32 command bits are sent.
- R3: While a frame runs, MDC has a period of 2*(divider+1) system clock cycles, where the divider is configuration bits 6:0. MDC stays low while idle.
- R4: For a read (command bits 29:28 = 10), the output enable is low for 17 MDC cycles: the second turnaround bit (bit 16) and data bits 15..0. For any other opcode, all 32 bits are driven.
- R5: After a read, data register bits 15:0 hold the 16 bits sampled from MDIO (first sampled bit in bit 15), and bits 31:16 are unchanged. After a write, the register still holds the written word.
- R6: The end of a frame sets status bit 0. Writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R7: The interrupt output equals status bit 0 AND mask bit 0.
- R8: Status bit 1 is set from the cycle after the launching write until the frame ends. A data-register write while busy neither starts a frame nor changes the register.
- R9: MDIO output changes only while MDC is low, so it is stable throughout every high phase of MDC. MDIO input is sampled at the rising MDC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Masked completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO input value |

## Verification
The hardest case is the read path. The bench must behave as a PHY that puts each data bit on the line before the rising MDC edge at which the engine samples it. It must also do nothing during the turnaround bit that it cannot see directly. The bench model watches MDC and the output enable at the falling system clock edge. It counts the rising MDC edges that occur while the line is released. It skips the first of those edges, which is the turnaround, and then shifts out its 16-bit word one bit per rising edge. The busy-write case is reached by launching a slow frame with a large divider and writing the data register while that frame is in flight.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_MASK = 2'd3;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam int FRAME_W = 32;
  localparam int RDATA_W = 16;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap = en && (cnt_q >= div);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!en) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc  = mdc_q;
  assign rise = wrap && !mdc_q;
  assign fall = wrap && mdc_q;

  // R3: clock parked low once the engine is idle
  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
  // R3: at most one edge event per cycle
  p_one_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] cmd,
  input  logic               pre_en,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdc,
  input  logic               mdio_in,
  output logic               busy,
  output logic               mdio_out,
  output logic               mdio_oe,
  output logic               done,
  output logic               is_rd,
  output logic [RDATA_W-1:0] rd_data
);
  localparam int PRE_W    = $clog2(PRE_LEN + 1);
  localparam int POS_W    = $clog2(FRAME_W);
  localparam int REL_POS  = FRAME_W - RDATA_W - 1;
  localparam int DATA_POS = FRAME_W - RDATA_W;

  logic               busy_q, busy_d;
  logic [FRAME_W-1:0] cmd_q, cmd_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [POS_W-1:0]   pos_q, pos_d;
  logic [RDATA_W-1:0] cap_q, cap_d;
  logic               in_frame, last_bit, rd_op;

  assign rd_op    = (cmd_q[FRAME_W-3:FRAME_W-4] == OPC_READ);
  assign in_frame = (pre_q == '0);
  assign last_bit = (pos_q == POS_W'(FRAME_W - 1));

  always_comb begin
    busy_d = busy_q;
    cmd_d  = cmd_q;
    pre_d  = pre_q;
    pos_d  = pos_q;
    cap_d  = cap_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cmd_d  = cmd;
        pre_d  = pre_en ? PRE_W'(PRE_LEN) : '0;
        pos_d  = '0;
        cap_d  = '0;
      end
    end else begin
      if (fall) begin
        if (!in_frame)     pre_d  = pre_q - 1'b1;
        else if (last_bit) busy_d = 1'b0;
        else               pos_d  = pos_q + 1'b1;
      end
      if (rise && rd_op && in_frame && (pos_q >= POS_W'(DATA_POS)))
        cap_d = {cap_q[RDATA_W-2:0], mdio_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      pre_q  <= '0;
      pos_q  <= '0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cmd_q  <= cmd_d;
      pre_q  <= pre_d;
      pos_q  <= pos_d;
      cap_q  <= cap_d;
    end
  end

  assign busy     = busy_q;
  assign done     = busy_q && fall && in_frame && last_bit;
  assign is_rd    = rd_op;
  assign rd_data  = cap_q;
  assign mdio_out = busy_q && (!in_frame || cmd_q[POS_W'(FRAME_W - 1) - pos_q]);
  assign mdio_oe  = busy_q && !(rd_op && in_frame && (pos_q >= POS_W'(REL_POS)));

  // R9: no output change during a high MDC phase
  p_out_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_out));
  // R8: a launch makes the engine busy in the next cycle
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy);
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 7,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int CFG_W = DIV_W + 1;

  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  logic [CFG_W-1:0]   cfg_q, cfg_d;
  logic [FRAME_W-1:0] data_q, data_d;
  logic               flag_q, flag_d;
  logic               mask_q, mask_d;
  logic               busy, done, is_rd, rise, fall, start;
  logic               wr_cfg, wr_data, wr_stat, wr_mask;
  logic [RDATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign wr_cfg  = reg_wr_en && (reg_addr == ADDR_CFG);
  assign wr_data = reg_wr_en && (reg_addr == ADDR_DATA);
  assign wr_stat = reg_wr_en && (reg_addr == ADDR_STAT);
  assign wr_mask = reg_wr_en && (reg_addr == ADDR_MASK);
  assign start   = wr_data && !busy;

  always_comb begin
    cfg_d  = cfg_q;
    data_d = data_q;
    flag_d = flag_q;
    mask_d = mask_q;
    if (wr_cfg)  cfg_d  = reg_wdata[CFG_W-1:0];
    if (wr_mask) mask_d = reg_wdata[0];
    if (start)   data_d = reg_wdata;
    if (done && is_rd) data_d[RDATA_W-1:0] = rd_data;
    if (done)    flag_d = 1'b1;
    else if (wr_stat && reg_wdata[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cfg_q  <= '0;
      data_q <= '0;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      data_q <= data_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CFG:  reg_rdata = 32'(cfg_q);
      ADDR_DATA: reg_rdata = data_q;
      ADDR_STAT: reg_rdata = {30'd0, busy, flag_q};
      default:   reg_rdata = {31'd0, mask_q};
    endcase
  end

  assign irq = flag_q && mask_q;

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (busy),
    .div   (cfg_q[DIV_W-1:0]),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (start),
    .cmd      (reg_wdata),
    .pre_en   (cfg_q[DIV_W]),
    .rise     (rise),
    .fall     (fall),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .busy     (busy),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .done     (done),
    .is_rd    (is_rd),
    .rd_data  (rd_data)
  );

  // R6: end of frame raises the completion flag
  p_done_flag_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> flag_q);
  // R8: data writes during a frame are dropped
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && wr_data && !done) |=> (data_q == $past(data_q)));
  // R4: line released whenever no frame is running
  p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> !mdio_oe);
endmodule

// File: tb/mdio_frame_engine_tb.sv
`timescale 1ns/1ps
module mdio_frame_engine_tb;
  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, mdc, mdio_out, mdio_oe;
  logic        mdio_in;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  localparam int NV = 6;
  localparam logic [31:0] V_CMD [NV] = '{32'h5192A5C3, 32'h608A0000, 32'h6FFE00FF,
                                         32'h5002FFFF, 32'h60020000, 32'h5FFE0000};
  localparam logic [7:0]  V_CFG [NV] = '{8'h81, 8'h80, 8'h03, 8'h00, 8'h82, 8'h9F};
  localparam logic [15:0] V_PHY [NV] = '{16'h0000, 16'hBEEF, 16'h1234,
                                         16'h0000, 16'h8001, 16'h0000};

  mdio_frame_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Bench-side PHY and line monitor, evaluated away from the active edge
  logic [15:0] phy_word;
  logic [15:0] phy_sh;
  logic [63:0] mon;
  int          nbits, nlow, phy_cnt, viol;
  longint      cyc, last_rise, per_last;
  logic        mdc_prev, out_prev;

  initial begin
    phy_word = '0; phy_sh = '0; mon = '0; nbits = 0; nlow = 0; phy_cnt = 0;
    viol = 0; cyc = 0; last_rise = 0; per_last = 0; mdc_prev = 0; out_prev = 0;
  end

  assign mdio_in = phy_sh[15];

  always @(negedge clk) begin
    cyc++;
    if (mdc && mdc_prev && (mdio_out !== out_prev)) viol++;
    if (mdc && !mdc_prev) begin
      per_last  = cyc - last_rise;
      last_rise = cyc;
      nbits++;
      mon = {mon[62:0], mdio_oe ? mdio_out : 1'b0};
      if (mdio_oe) begin
        phy_cnt = 0;
        phy_sh  = phy_word;
      end else begin
        nlow++;
        if (phy_cnt != 0) phy_sh = {phy_sh[14:0], 1'b0};
        phy_cnt++;
      end
    end
    mdc_prev = mdc;
    out_prev = mdio_out;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      rd(2'd2, s);
      if (s[0]) break;
    end
  endtask

  task automatic run_op(input logic [31:0] cmd, input logic [7:0] cfg,
                        input logic [15:0] phy);
    int b0, l0;
    bit rdop, pre;
    logic [31:0] frame, d, expd;
    logic [63:0] expm;
    rdop = (cmd[29:28] == 2'b10);
    pre  = cfg[7];
    wr(2'd2, 32'h1);
    wr(2'd0, {24'd0, cfg});
    phy_word = phy;
    b0 = nbits; l0 = nlow;
    wr(2'd1, cmd);
    wait_done();
    repeat (2) @(negedge clk);
    frame = rdop ? {cmd[31:17], 17'd0} : cmd;
    if (pre) begin
      expm = {32'hFFFF_FFFF, frame};
      chk(mon == expm, "R2 frame with preamble", mon, expm);
    end else begin
      chk(mon[31:0] == frame, "R2 frame without preamble", {32'd0, mon[31:0]}, {32'd0, frame});
    end
    chk((nbits - b0) == (pre ? 64 : 32), "R2 bit count", 64'(nbits - b0), pre ? 64 : 32);
    chk((nlow - l0) == (rdop ? 17 : 0), "R4 released bit count", 64'(nlow - l0), rdop ? 17 : 0);
    chk(per_last == 2 * (cfg[6:0] + 1), "R3 mdc period", 64'(per_last), 64'(2 * (cfg[6:0] + 1)));
    expd = rdop ? {cmd[31:16], phy} : cmd;
    rd(2'd1, d);
    chk(d == expd, "R5 data register", 64'(d), 64'(expd));
    rd(2'd2, d);
    chk(d == 32'h1, "R6 done flag set, busy clear", 64'(d), 64'h1);
    chk(!mdc && !mdio_oe, "R3 idle mdc low", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    logic [31:0] d;
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 32'd0, "R1 register reset", 64'(d), 64'd0);
    end
    chk(!mdc && !mdio_oe && !irq, "R1 pins after reset", {61'd0, mdc, mdio_oe, irq}, 64'd0);

    // Vector table
    for (int k = 0; k < NV; k++) run_op(V_CMD[k], V_CFG[k], V_PHY[k]);

    // R6: writing 0 keeps the flag, writing 1 clears it
    wr(2'd2, 32'h0);
    rd(2'd2, d);
    chk(d[0] == 1'b1, "R6 write zero keeps flag", 64'(d[0]), 64'd1);
    // R7: mask gating
    chk(irq == 1'b0, "R7 masked irq low", 64'(irq), 64'd0);
    wr(2'd3, 32'h1);
    #1;
    chk(irq == 1'b1, "R7 unmasked irq high", 64'(irq), 64'd1);
    wr(2'd2, 32'h1);
    rd(2'd2, d);
    chk(d[0] == 1'b0, "R6 write one clears flag", 64'(d[0]), 64'd0);
    chk(irq == 1'b0, "R7 irq follows cleared flag", 64'(irq), 64'd0);

    // R8: busy flag and ignored data writes
    wr(2'd0, 32'h0000_0005);
    phy_word = 16'hC3A5;
    wr(2'd1, 32'h6042_0000);
    repeat (5) @(negedge clk);
    rd(2'd2, d);
    chk(d[1] == 1'b1, "R8 busy during frame", 64'(d[1]), 64'd1);
    wr(2'd1, 32'h5123_4567);
    rd(2'd1, d);
    chk(d == 32'h6042_0000, "R8 write while busy dropped", 64'(d), 64'h6042_0000);
    wait_done();
    repeat (2) @(negedge clk);
    rd(2'd1, d);
    chk(d == 32'h6042_C3A5, "R8 R5 frame unaffected by busy write", 64'(d), 64'h6042_C3A5);
    rd(2'd2, d);
    chk(d[1] == 1'b0, "R8 busy clear after frame", 64'(d[1]), 64'd0);

    // R9: no output change during MDC high across all frames
    chk(viol == 0, "R9 output stable while mdc high", 64'(viol), 64'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule